// File: doc/BRIEF.md
# Packed Lane Add/Subtract with Saturation

This unit adds or subtracts two 64-bit words treated as a packed vector of independent integer lanes. Software or a surrounding datapath picks the lane width (4, 8, 16 or 32 bits) and one of four overflow policies for every operation. The policies are plain modulo arithmetic, clamping to the unsigned range, clamping to the two's-complement range, and a mixed policy. In the mixed policy the first operand is read as unsigned, the second as signed, and the result is clamped to the unsigned range.

An operation is offered with a one-cycle valid strobe. The packed result, a valid flag and a set of per-nibble clamp flags leave a single output register on the next clock edge. Each lane is computed with no carry or borrow passing into its neighbour, so the same hardware serves many small pixels or a few wide words.

Top module: `simd_sat_addsub`

## Requirements
- R1: When `in_valid` is high at a clock edge, `out_valid` is high for exactly the following cycle with the result of that operation; when `in_valid` is low, `out_valid` is low in the following cycle.
- R2: With `in_mode` = 0 (wrap), each lane result is the lane sum or difference modulo 2^t, and every clamp flag is 0.
- R3: With `in_mode` = 1 (unsigned clamp), operands are unsigned; a result above 2^t-1 becomes all ones and a result below 0 becomes 0.
- R4: With `in_mode` = 2 (signed clamp), operands are two's-complement; results are clamped to the range -2^(t-1) to 2^(t-1)-1, for example 80h to 7Fh for bytes.
- R5: With `in_mode` = 3 (mixed clamp), the lane of `in_a` is unsigned, the lane of `in_b` is signed, and the result is clamped to 0 to 2^t-1.
- R6: `in_size` selects the lane width t: 0 gives 4 bits, 1 gives 8, 2 gives 16 and 3 gives 32. No carry or borrow crosses a lane boundary, and lane k occupies bits k*t to k*t+t-1.
- R7: Bit n of `out_sat` covers result bits 4n to 4n+3. It is 1 exactly when clamping changed the lane holding that nibble, and it is equal across all nibbles of one lane.
- R8: While `in_valid` is low, `out_result` and `out_sat` keep their last values whatever the other inputs do.
- R9: During a synchronous reset (`rst_n` low at a clock edge), `out_valid`, `out_result` and `out_sat` become 0.
- R10: `in_sub` = 0 computes `in_a` + `in_b` per lane; `in_sub` = 1 computes `in_a` - `in_b` per lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| in_a | input | 64 | First packed operand |
| in_b | input | 64 | Second packed operand |
| in_sub | input | 1 | 0 add, 1 subtract |
| in_size | input | 2 | Lane width select |
| in_mode | input | 2 | Overflow policy select |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| out_result | output | 64 | Packed result |
| out_sat | output | 16 | Clamp flags, one per nibble position |

## Verification
The case that most often hides a bug is a clamp in one lane happening in the same cycle as a raw carry or borrow out of its neighbour. Separate per-lane logic computes both, and a mistake in either spills into the other. The byte vectors place `FF+01`, `80+80` and `01-FF` next to lanes that stay within range, so that a clamp and a discarded carry sit side by side in one word. Each lane value and each replicated flag pair is then compared against hand-derived expectations. A second directed case adds ones to every all-ones byte in wrap mode, where any leaked carry would turn a zero lane into a one.

// File: rtl/simd_pkg.sv
// Shared encodings for the packed add/subtract unit.
// Assumes a 4-bit nibble as the smallest lane and flag granule.
package simd_pkg;

    typedef enum logic [1:0] {
        LANE_NIB  = 2'd0,
        LANE_BYTE = 2'd1,
        LANE_HALF = 2'd2,
        LANE_WORD = 2'd3
    } lane_size_e;

    typedef enum logic [1:0] {
        MODE_WRAP  = 2'd0,
        MODE_USAT  = 2'd1,
        MODE_SSAT  = 2'd2,
        MODE_MIXED = 2'd3
    } sat_mode_e;

    localparam int NIB_W     = 4;
    localparam int NUM_SIZES = 4;

endpackage

// File: rtl/simd_lane_unit.sv
// One lane of W bits: add or subtract with a selectable overflow policy.
// Assumes W >= 2. Works in W+2 bits so that every raw result of every
// policy fits without loss before clamping.
module simd_lane_unit
    import simd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         op_sub,
    input  logic [1:0]   mode,
    output logic [W-1:0] res,
    output logic         clamped
);
    localparam int XW = W + 2;

    logic              a_is_signed;
    logic              b_is_signed;
    logic              clamp_on;
    logic              above;
    logic              below;
    logic signed [XW-1:0] wide_a;
    logic signed [XW-1:0] wide_b;
    logic signed [XW-1:0] raw;
    logic signed [XW-1:0] top_lim;
    logic signed [XW-1:0] bot_lim;

    // Extend operands by policy and form the exact wide result.
    always_comb begin
        a_is_signed = (mode == MODE_SSAT);
        b_is_signed = (mode == MODE_SSAT) || (mode == MODE_MIXED);
        wide_a = a_is_signed ? {{2{op_a[W-1]}}, op_a} : {2'b00, op_a};
        wide_b = b_is_signed ? {{2{op_b[W-1]}}, op_b} : {2'b00, op_b};
        raw    = op_sub ? (wide_a - wide_b) : (wide_a + wide_b);
    end

    // Pick the clamp limits and apply them unless the policy is wrap.
    always_comb begin
        top_lim  = a_is_signed ? {3'b000, {(W-1){1'b1}}} : {2'b00, {W{1'b1}}};
        bot_lim  = a_is_signed ? {3'b111, {(W-1){1'b0}}} : '0;
        clamp_on = (mode != MODE_WRAP);
        above    = clamp_on && (raw > top_lim);
        below    = clamp_on && (raw < bot_lim);
        if (above) begin
            res = top_lim[W-1:0];
        end else if (below) begin
            res = bot_lim[W-1:0];
        end else begin
            res = raw[W-1:0];
        end
        clamped = above || below;
    end

endmodule

// File: rtl/simd_width_bank.sv
// All lanes of one fixed width across the data word, with the clamp flag
// of each lane copied onto every nibble position it covers.
// Assumes DATA_W is a multiple of LANE_W and LANE_W a multiple of NIB_W.
module simd_width_bank
    import simd_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0]       src_a,
    input  logic [DATA_W-1:0]       src_b,
    input  logic                    do_sub,
    input  logic [1:0]              mode,
    output logic [DATA_W-1:0]       bank_res,
    output logic [DATA_W/NIB_W-1:0] bank_flags
);
    localparam int LANES    = DATA_W / LANE_W;
    localparam int NIBS_PER = LANE_W / NIB_W;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic lane_clamp;

        simd_lane_unit #(.W(LANE_W)) u_lane (
            .op_a    (src_a[k*LANE_W +: LANE_W]),
            .op_b    (src_b[k*LANE_W +: LANE_W]),
            .op_sub  (do_sub),
            .mode    (mode),
            .res     (bank_res[k*LANE_W +: LANE_W]),
            .clamped (lane_clamp)
        );

        // Replicate this lane's flag over its nibble positions.
        assign bank_flags[k*NIBS_PER +: NIBS_PER] = {NIBS_PER{lane_clamp}};
    end

endmodule

// File: rtl/simd_sat_addsub.sv
// Packed add/subtract with wrap, unsigned, signed or mixed clamping.
// Computes every lane width in parallel, selects one by in_size and
// registers the choice. Assumes DATA_W is a multiple of the widest lane.
module simd_sat_addsub
    import simd_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [DATA_W-1:0]       in_a,
    input  logic [DATA_W-1:0]       in_b,
    input  logic                    in_sub,
    input  logic [1:0]              in_size,
    input  logic [1:0]              in_mode,
    output logic                    out_valid,
    output logic [DATA_W-1:0]       out_result,
    output logic [DATA_W/NIB_W-1:0] out_sat
);
    localparam int FLAG_W = DATA_W / NIB_W;
    localparam int WORD_W = NIB_W << (NUM_SIZES - 1);

    logic [DATA_W-1:0] bank_res [NUM_SIZES];
    logic [FLAG_W-1:0] bank_flg [NUM_SIZES];
    logic [DATA_W-1:0] sel_res;
    logic [FLAG_W-1:0] sel_flg;

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_bank
        simd_width_bank #(
            .LANE_W (NIB_W << s),
            .DATA_W (DATA_W)
        ) u_bank (
            .src_a      (in_a),
            .src_b      (in_b),
            .do_sub     (in_sub),
            .mode       (in_mode),
            .bank_res   (bank_res[s]),
            .bank_flags (bank_flg[s])
        );
    end

    // Choose the bank matching the requested lane width.
    always_comb begin
        sel_res = bank_res[in_size];
        sel_flg = bank_flg[in_size];
    end

    // Output register: capture on a strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_result <= '0;
            out_sat    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result <= sel_res;
                out_sat    <= sel_flg;
            end
        end
    end

    function automatic logic pairs_match(input logic [FLAG_W-1:0] f);
        for (int i = 0; i < FLAG_W / 2; i++) begin
            if (f[2*i] != f[2*i+1]) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic logic word_clamp_ok(input logic [DATA_W-1:0] r,
                                           input logic [FLAG_W-1:0] f);
        for (int k = 0; k < DATA_W / WORD_W; k++) begin
            if (f[k*(WORD_W/NIB_W)]) begin
                if (r[k*WORD_W +: WORD_W] != {1'b0, {(WORD_W-1){1'b1}}} &&
                    r[k*WORD_W +: WORD_W] != {1'b1, {(WORD_W-1){1'b0}}})
                    return 1'b0;
            end
        end
        return 1'b1;
    endfunction

    // R1: a strobe yields a valid result on the next cycle
    p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R1: no strobe, no valid result on the next cycle
    p_valid_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R2: wrap policy never raises a clamp flag
    p_wrap_noflag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == MODE_WRAP) |=> (out_sat == '0));

    // R4: a clamped signed word lane holds one of the two signed limits
    p_word_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == MODE_SSAT && in_size == LANE_WORD)
        |=> word_clamp_ok(out_result, out_sat));

    // R7: byte-lane flags are equal across both nibbles of every lane
    p_flag_pairs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_size == LANE_BYTE) |=> pairs_match(out_sat));

    // R8: outputs hold while no operation is offered
    p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_result) && $stable(out_sat)));

endmodule

// File: tb/simd_sat_addsub_tb_top.sv
// Bench: vector table walked by one loop, then directed reset, latency,
// hold, carry-isolation and subtract checks.
module simd_sat_addsub_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_a = '0;
    logic [63:0] in_b = '0;
    logic        in_sub = 1'b0;
    logic [1:0]  in_size = '0;
    logic [1:0]  in_mode = '0;
    logic        out_valid;
    logic [63:0] out_result;
    logic [15:0] out_sat;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    simd_sat_addsub dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_a       (in_a),
        .in_b       (in_b),
        .in_sub     (in_sub),
        .in_size    (in_size),
        .in_mode    (in_mode),
        .out_valid  (out_valid),
        .out_result (out_result),
        .out_sat    (out_sat)
    );

    // {sub, size, mode, a, b, expected result, expected flags}
    localparam int NV = 18;
    localparam logic [212:0] VEC [NV] = '{
        {1'b0, 2'd1, 2'd0, 64'h5580_7FFF_00AA_0180, 64'h3A80_0101_FF2A_FF7F, 64'h8F00_8000_FFD4_00FF, 16'h0000},
        {1'b0, 2'd1, 2'd1, 64'h5580_7FFF_00AA_0180, 64'h3A80_0101_FF2A_FF7F, 64'h8FFF_80FF_FFD4_FFFF, 16'h330C},
        {1'b0, 2'd1, 2'd2, 64'h5580_7FFF_00AA_0180, 64'h3A80_0101_FF2A_FF7F, 64'h7F80_7F00_FFD4_00FF, 16'hFC00},
        {1'b0, 2'd1, 2'd3, 64'h5580_7FFF_00AA_0180, 64'h3A80_0101_FF2A_FF7F, 64'h8F00_80FF_00D4_00FF, 16'h03C0},
        {1'b1, 2'd1, 2'd0, 64'h5580_7FFF_00AA_0180, 64'h3A80_0101_FF2A_FF7F, 64'h1B00_7EFE_0180_0201, 16'h0000},
        {1'b1, 2'd1, 2'd1, 64'h5580_7FFF_00AA_0180, 64'h3A80_0101_FF2A_FF7F, 64'h1B00_7EFE_0080_0001, 16'h00CC},
        {1'b1, 2'd1, 2'd2, 64'h5580_7FFF_00AA_0180, 64'h3A80_0101_FF2A_FF7F, 64'h1B00_7EFE_0180_0280, 16'h0003},
        {1'b1, 2'd1, 2'd3, 64'h5580_7FFF_00AA_0180, 64'h3A80_0101_FF2A_FF7F, 64'h1BFF_7EFE_0180_0201, 16'h3000},
        {1'b0, 2'd0, 2'd0, 64'hFEDC_BA98_7654_3210, 64'h1111_1111_1111_1111, 64'h0FED_CBA9_8765_4321, 16'h0000},
        {1'b0, 2'd0, 2'd1, 64'hFEDC_BA98_7654_3210, 64'h1111_1111_1111_1111, 64'hFFED_CBA9_8765_4321, 16'h8000},
        {1'b0, 2'd0, 2'd2, 64'hFEDC_BA98_7654_3210, 64'h1111_1111_1111_1111, 64'h0FED_CBA9_7765_4321, 16'h0080},
        {1'b0, 2'd0, 2'd3, 64'hFEDC_BA98_7654_3210, 64'h1111_1111_1111_1111, 64'hFFED_CBA9_8765_4321, 16'h8000},
        {1'b0, 2'd2, 2'd2, 64'h7FFF_8000_1234_FFFF, 64'h0001_FFFF_4000_0001, 64'h7FFF_8000_5234_0000, 16'hFF00},
        {1'b0, 2'd2, 2'd0, 64'h7FFF_8000_1234_FFFF, 64'h0001_FFFF_4000_0001, 64'h8000_7FFF_5234_0000, 16'h0000},
        {1'b0, 2'd2, 2'd1, 64'h7FFF_8000_1234_FFFF, 64'h0001_FFFF_4000_0001, 64'h8000_FFFF_5234_FFFF, 16'h0F0F},
        {1'b1, 2'd3, 2'd3, 64'h0000_0005_FFFF_FFFF, 64'h0000_0006_8000_0000, 64'h0000_0000_FFFF_FFFF, 16'hFFFF},
        {1'b0, 2'd3, 2'd2, 64'h7FFF_FFFF_0000_0010, 64'h0000_0001_FFFF_FFF0, 64'h7FFF_FFFF_0000_0000, 16'hFF00},
        {1'b0, 2'd3, 2'd0, 64'h7FFF_FFFF_0000_0010, 64'h0000_0001_FFFF_FFF0, 64'h8000_0000_0000_0000, 16'h0000}
    };

    task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Offer one operation at a falling edge; return one cycle later,
    // after the capturing rising edge.
    task automatic run_op(input logic s, input logic [1:0] sz, input logic [1:0] md,
                          input logic [63:0] a, input logic [63:0] b);
        @(negedge clk);
        in_sub = s; in_size = sz; in_mode = md; in_a = a; in_b = b;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic string mode_tag(input logic [1:0] md);
        case (md)
            2'd0:    return "R2 wrap";
            2'd1:    return "R3 unsigned";
            2'd2:    return "R4 signed";
            default: return "R5 mixed";
        endcase
    endfunction

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] held_r;
        logic [15:0] held_s;

        // R9: reset clears outputs
        repeat (3) @(negedge clk);
        check64("R9 reset valid", {63'd0, out_valid}, 64'd0);
        check64("R9 reset result", out_result, 64'd0);
        check64("R9 reset flags", {48'd0, out_sat}, 64'd0);
        rst_n = 1'b1;

        // Vector table: results (R2..R6, R10) and flags (R7)
        for (int v = 0; v < NV; v++) begin
            run_op(VEC[v][212], VEC[v][211:210], VEC[v][209:208],
                   VEC[v][207:144], VEC[v][143:80]);
            check64($sformatf("%s vec %0d", mode_tag(VEC[v][209:208]), v),
                    out_result, VEC[v][79:16]);
            check64($sformatf("R7 flags vec %0d", v), {48'd0, out_sat}, {48'd0, VEC[v][15:0]});
        end

        // R1: valid for one cycle after the strobe only
        run_op(1'b0, 2'd1, 2'd0, 64'h0102_0304_0506_0708, 64'h1010_1010_1010_1010);
        check64("R1 valid after strobe", {63'd0, out_valid}, 64'd1);
        check64("R1 result", out_result, 64'h1112_1314_1516_1718);
        held_r = out_result;
        held_s = out_sat;

        // R8: inputs change without a strobe; outputs hold
        in_a = 64'hFFFF_FFFF_FFFF_FFFF; in_b = 64'hFFFF_FFFF_FFFF_FFFF;
        in_mode = 2'd1;
        @(negedge clk);
        check64("R1 valid drops", {63'd0, out_valid}, 64'd0);
        check64("R8 result held", out_result, held_r);
        check64("R8 flags held", {48'd0, out_sat}, {48'd0, held_s});

        // R6: all-ones bytes plus one wrap to zero with no carry leakage
        run_op(1'b0, 2'd1, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101);
        check64("R6 byte carry isolation", out_result, 64'h0000_0000_0000_0000);
        // R6: same operands as halfwords carry within each lane only
        run_op(1'b0, 2'd2, 2'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101);
        check64("R6 half lanes", out_result, 64'h0100_0100_0100_0100);

        // R10: subtract direction, word wrap 5-6 and 0-1
        run_op(1'b1, 2'd3, 2'd0, 64'h0000_0005_0000_0000, 64'h0000_0006_0000_0001);
        check64("R10 word subtract", out_result, 64'hFFFF_FFFF_FFFF_FFFF);

        // R9: reset in mid-run clears a held result
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check64("R9 mid reset result", out_result, 64'd0);
        check64("R9 mid reset valid", {63'd0, out_valid}, 64'd0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule